// File: doc/BRIEF.md
# External Bus Read-Cycle Controller with Acknowledge Stretch

This block runs asynchronous read cycles on an external parallel bus toward a slow peripheral. The host raises a request with an address while the controller is idle. The controller then drives an address-latch strobe, chip select and output enable, samples the read data and returns it with a one-clock ready pulse. Every timing is programmed in clocks: total cycle length, chip-select assertion delay, chip-select negation lead, acknowledge polarity and acknowledge sampling point. The controller latches all of these when it accepts a request, so they hold for the whole cycle.

In fixed mode the cycle always takes the programmed number of clocks. In acknowledge mode the peripheral paces the cycle. The acknowledge input passes through a two-flop synchroniser. If the acknowledge has not been seen by the last clock of the nominal chip-select window, the controller freezes there. Chip select stays active until the acknowledge arrives, so its active time is the nominal window plus the wait. After the acknowledge, the negation-lead clocks run out and the cycle ends. A fixed timeout ends a cycle that gets no acknowledge and flags an error.

Top module: `bus_read_ctrl`

## Requirements
- R1: After reset, `bus_cs_n_o` and `bus_oe_n_o` are high, and `bus_ale_o`, `ready_o` and `err_o` are low.
- R2: With `ack_mode_i`=0 and cycle length W, counter t counts the cycle clocks from 0. The cycle lasts exactly W clocks. `ready_o` appears in the clock after the last one, which is clock index W counting the accepting edge as the start of clock 0. `bus_ack_i` has no effect in this mode.
- R3: `bus_ale_o` is high in clock 0 of a cycle only. `bus_addr_o` shows the address captured at acceptance and keeps it until ready, whatever `addr_i` does during the cycle.
- R4: `bus_oe_n_o` equals `bus_cs_n_o` in every clock.
- R5: In fixed mode, `rdata_o` takes the value `bus_data_i` had in the last cycle clock (t = W-1).
- R6: In acknowledge mode, the sampling point is S = 3 + `ack_smp_i` (2-bit field). The acknowledge is seen two clocks after it arrives at the pin. Data is captured in the first clock with t ≥ S in which the synchronised acknowledge is active.
- R7: Chip select is active for t in [`cs_dly_i`, W − `cs_lead_i`). In acknowledge mode, t holds at W − `cs_lead_i` − 1 until the acknowledge is seen, and then the `cs_lead_i` trailing clocks run. With no delay, a 28-clock cycle, a lead of 3 and the acknowledge seen in clock k ≥ 24, chip select is low for k+1 clocks.
- R8: With `ack_pol_i`=0 a high `bus_ack_i` is the active level; with `ack_pol_i`=1 a low level is active.
- R9: In acknowledge mode, if no acknowledge is seen in the 255 clocks from t = S onward, the cycle ends. `ready_o` and `err_o` pulse together in the next clock, chip select negates, and `rdata_o` keeps its previous value.
- R10: `ready_o` lasts exactly one clock, and `err_o` is never high without `ready_o`.

Configuration constraints: `cs_lead_i` ≥ 1, `cs_dly_i` < W − `cs_lead_i`, and S ≤ W − `cs_lead_i` − 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Read request, accepted while idle |
| addr_i | input | ADDR_W | Read address |
| wait_cnt_i | input | CNT_W | Cycle length W in clocks |
| cs_dly_i | input | CNT_W | Chip-select assertion delay |
| cs_lead_i | input | CNT_W | Chip-select negation lead before cycle end |
| ack_mode_i | input | 1 | 1 = acknowledge-paced cycle |
| ack_pol_i | input | 1 | 0 = acknowledge active high, 1 = active low |
| ack_smp_i | input | 2 | Sampling point code, S = 3 + code |
| ready_o | output | 1 | One-clock completion pulse |
| err_o | output | 1 | Timeout flag, valid with ready |
| rdata_o | output | DATA_W | Captured read data |
| bus_cs_n_o | output | 1 | Chip select, active low |
| bus_oe_n_o | output | 1 | Output enable, active low |
| bus_ale_o | output | 1 | Address latch strobe |
| bus_addr_o | output | ADDR_W | Bus address |
| bus_data_i | input | DATA_W | Bus read data |
| bus_ack_i | input | 1 | Peripheral data acknowledge |

## Verification
A wrong cycle counter or a missed stall moves the chip-select edges. The error shows in the measured low-time of `bus_cs_n_o` and in the clock index of `ready_o` within the same cycle. A capture taken at the wrong clock shows in `rdata_o` at the ready pulse, because the bench makes the data bus valid for exactly one clock. A broken synchroniser or polarity stretches or shortens the stall, or it ends in the timeout, which is visible within a few hundred clocks.

// File: rtl/brc_pkg.sv
package brc_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} brc_state_e;
  localparam int SMP_BASE    = 3;
  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/brc_ack_sync.sv
module brc_ack_sync #(
  parameter int STAGES = brc_pkg::SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_raw_i,
  input  logic pol_i,
  output logic ack_o
);
  logic [STAGES-1:0] sync_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[g] <= 1'b0;
        else if (g == 0) sync_q[g] <= ack_raw_i;
        else sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign ack_o = sync_q[STAGES-1] ^ pol_i;
endmodule

// File: rtl/brc_timeout.sv
module brc_timeout #(
  parameter int TO_LIMIT = 255,
  localparam int TO_W = $clog2(TO_LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic expire_o
);
  logic [TO_W-1:0] cnt_q;

  assign expire_o = run_i && (cnt_q == TO_W'(TO_LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (run_i && !expire_o) cnt_q <= cnt_q + TO_W'(1);
  end

  AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= TO_W'(TO_LIMIT - 1)); // R9
endmodule

// File: rtl/brc_seq.sv
module brc_seq
  import brc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [CNT_W-1:0] wait_cnt_i,
  input  logic [CNT_W-1:0] cs_dly_i,
  input  logic [CNT_W-1:0] cs_lead_i,
  input  logic             ack_mode_i,
  input  logic             ack_pol_i,
  input  logic [1:0]       ack_smp_i,
  input  logic             ack_i,
  input  logic             expire_i,
  output logic             start_o,
  output logic             capture_o,
  output logic             finish_o,
  output logic             abort_o,
  output logic             to_run_o,
  output logic             pol_o,
  output logic             run_o,
  output logic             cs_o,
  output logic             ale_o
);
  brc_state_e       state_q;
  logic [CNT_W-1:0] t_q, w_q, dly_q, lead_q, smp_q;
  logic             mode_q, pol_q, seen_q;
  logic [CNT_W-1:0] last_t, tail_t, hold_t;
  logic             in_run, at_smp, ack_now, stall;

  assign in_run  = (state_q == ST_RUN);
  assign last_t  = w_q - CNT_W'(1);
  assign tail_t  = w_q - lead_q;
  assign hold_t  = tail_t - CNT_W'(1);
  assign at_smp  = (t_q >= smp_q);
  assign ack_now = in_run && mode_q && at_smp && !seen_q && ack_i;
  // freeze on the last nominal chip-select clock until acknowledged
  assign stall   = in_run && mode_q && (t_q == hold_t) && !seen_q && !ack_now;

  assign start_o   = (state_q == ST_IDLE) && req_i;
  assign to_run_o  = in_run && mode_q && at_smp && !seen_q;
  assign abort_o   = expire_i && !ack_now;
  assign capture_o = mode_q ? ack_now : (in_run && (t_q == last_t));
  assign finish_o  = in_run && (((t_q == last_t) && !stall) || abort_o);
  assign cs_o      = in_run && (t_q >= dly_q) && (t_q < tail_t);
  assign ale_o     = in_run && (t_q == '0);
  assign pol_o     = pol_q;
  assign run_o     = in_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      t_q     <= '0;
      w_q     <= '0;
      dly_q   <= '0;
      lead_q  <= '0;
      smp_q   <= '0;
      mode_q  <= 1'b0;
      pol_q   <= 1'b0;
      seen_q  <= 1'b0;
    end else if (start_o) begin
      state_q <= ST_RUN;
      t_q     <= '0;
      w_q     <= wait_cnt_i;
      dly_q   <= cs_dly_i;
      lead_q  <= cs_lead_i;
      smp_q   <= {{(CNT_W-2){1'b0}}, ack_smp_i} + CNT_W'(SMP_BASE);
      mode_q  <= ack_mode_i;
      pol_q   <= ack_pol_i;
      seen_q  <= 1'b0;
    end else if (in_run) begin
      if (finish_o) state_q <= ST_IDLE;
      else if (!stall) t_q <= t_q + CNT_W'(1);
      if (ack_now) seen_q <= 1'b1;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(stall) && in_run |-> t_q == $past(t_q)); // R7
  AST_TIMEOUT_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> mode_q && !seen_q); // R9
  AST_FIXED_NO_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_run && !mode_q |-> !seen_q); // R2
endmodule

// File: rtl/bus_read_ctrl.sv
module bus_read_ctrl #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int CNT_W    = 8,
  parameter int TO_LIMIT = 255
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wait_cnt_i,
  input  logic [CNT_W-1:0]  cs_dly_i,
  input  logic [CNT_W-1:0]  cs_lead_i,
  input  logic              ack_mode_i,
  input  logic              ack_pol_i,
  input  logic [1:0]        ack_smp_i,
  output logic              ready_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              bus_cs_n_o,
  output logic              bus_oe_n_o,
  output logic              bus_ale_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic              bus_ack_i
);
  logic              ack_s, expire, start, capture, finish, abort, to_run, pol, run, cs, ale;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] rdata_q;
  logic              ready_q, err_q;

  brc_ack_sync u_sync (
    .clk_i, .rst_ni, .ack_raw_i(bus_ack_i), .pol_i(pol), .ack_o(ack_s)
  );

  brc_timeout #(.TO_LIMIT(TO_LIMIT)) u_to (
    .clk_i, .rst_ni, .clr_i(start), .run_i(to_run), .expire_o(expire)
  );

  brc_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i, .rst_ni, .req_i,
    .wait_cnt_i, .cs_dly_i, .cs_lead_i, .ack_mode_i, .ack_pol_i, .ack_smp_i,
    .ack_i(ack_s), .expire_i(expire),
    .start_o(start), .capture_o(capture), .finish_o(finish), .abort_o(abort),
    .to_run_o(to_run), .pol_o(pol), .run_o(run), .cs_o(cs), .ale_o(ale)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      rdata_q <= '0;
      ready_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (start)   addr_q  <= addr_i;
      if (capture) rdata_q <= bus_data_i;
      ready_q <= finish;
      err_q   <= abort;
    end
  end

  assign ready_o    = ready_q;
  assign err_o      = err_q;
  assign rdata_o    = rdata_q;
  assign bus_cs_n_o = ~cs;
  assign bus_oe_n_o = ~cs;
  assign bus_ale_o  = ale;
  assign bus_addr_o = addr_q;

  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && $past(run) |-> $stable(addr_q)); // R3
  AST_READY_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o); // R10
  AST_ERR_WITH_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ready_o); // R10
  AST_CS_OFF_AT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> bus_cs_n_o); // R9
endmodule

// File: tb/bus_read_ctrl_test.sv
module bus_read_ctrl_test;
  logic        clk_i = 1'b0, rst_ni = 1'b0, req_i = 1'b0;
  logic [15:0] addr_i = '0, bus_data_i = '0;
  logic [7:0]  wait_cnt_i = 8'd28, cs_dly_i = '0, cs_lead_i = 8'd3;
  logic        ack_mode_i = 1'b0, ack_pol_i = 1'b0, bus_ack_i = 1'b0;
  logic [1:0]  ack_smp_i = '0;
  logic        ready_o, err_o, bus_cs_n_o, bus_oe_n_o, bus_ale_o;
  logic [15:0] rdata_o, bus_addr_o;
  int checks = 0, fails = 0;

  always #5 clk_i = ~clk_i;

  bus_read_ctrl uut (.*);

  typedef struct packed {
    logic mode; logic pol; logic [1:0] smp;
    logic [7:0] w; logic [7:0] dly; logic [7:0] lead;
    logic signed [15:0] ack_at;
    logic [15:0] cs; logic [15:0] rdy; logic [15:0] cap;
  } vec_t;

  // mode pol smp W dly lead ack_at | cs_low ready_clk capture_clk
  localparam vec_t VECS [7] = '{
    '{1'b0, 1'b0, 2'd0, 8'd28, 8'd0, 8'd3,  16'sd5,  16'd25, 16'd28, 16'd27},
    '{1'b1, 1'b0, 2'd0, 8'd28, 8'd0, 8'd3,  16'sd0,  16'd25, 16'd28, 16'd3},
    '{1'b1, 1'b0, 2'd0, 8'd28, 8'd0, 8'd3,  16'sd40, 16'd43, 16'd46, 16'd42},
    '{1'b1, 1'b1, 2'd0, 8'd28, 8'd0, 8'd3,  16'sd30, 16'd33, 16'd36, 16'd32},
    '{1'b0, 1'b0, 2'd0, 8'd10, 8'd2, 8'd1, -16'sd1,  16'd7,  16'd10, 16'd9},
    '{1'b1, 1'b0, 2'd0, 8'd10, 8'd2, 8'd1,  16'sd20, 16'd21, 16'd24, 16'd22},
    '{1'b1, 1'b0, 2'd2, 8'd28, 8'd0, 8'd3,  16'sd0,  16'd25, 16'd28, 16'd5}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_cycle(input vec_t v, input logic [15:0] addr, input logic [15:0] aval,
                           output int cs_cnt, output int first_cs, output int ale_cnt,
                           output int rdy_i, output int oe_bad, output int addr_bad,
                           output int after_rdy, output logic [15:0] data, output logic err);
    cs_cnt = 0; first_cs = -1; ale_cnt = 0; rdy_i = -1; oe_bad = 0; addr_bad = 0;
    data = '0; err = 1'b0;
    @(negedge clk_i);
    ack_mode_i = v.mode; ack_pol_i = v.pol; ack_smp_i = v.smp;
    wait_cnt_i = v.w; cs_dly_i = v.dly; cs_lead_i = v.lead;
    bus_ack_i = v.pol; bus_data_i = 16'h0BAD; addr_i = addr;
    repeat (3) @(negedge clk_i);
    req_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    req_i = 1'b0;
    for (int i = 0; i < 400; i++) begin
      if (!bus_cs_n_o) begin
        cs_cnt++;
        if (first_cs < 0) first_cs = i;
      end
      if (bus_ale_o) ale_cnt++;
      if (bus_oe_n_o != bus_cs_n_o) oe_bad++;
      if (ready_o) begin
        rdy_i = i; data = rdata_o; err = err_o;
        break;
      end
      if (bus_addr_o != addr) addr_bad++;
      if (i == v.ack_at) bus_ack_i = ~v.pol;
      if (i == v.cap) bus_data_i = aval;
      if (i == v.cap + 1) bus_data_i = ~aval;
      if (i == 1) addr_i = ~addr;
      @(negedge clk_i);
    end
    @(negedge clk_i);
    after_rdy = {30'd0, ready_o, bus_cs_n_o};
    bus_ack_i = v.pol;
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int cs_cnt, first_cs, ale_cnt, rdy_i, oe_bad, addr_bad, after_rdy;
    logic [15:0] data, last_data;
    logic err;
    #1;
    chk("R1 cs_n", bus_cs_n_o, 1);
    chk("R1 oe_n", bus_oe_n_o, 1);
    chk("R1 ale/ready/err", {bus_ale_o, ready_o, err_o}, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 cs_n after release", bus_cs_n_o, 1);

    last_data = '0;
    for (int k = 0; k < 7; k++) begin
      logic [15:0] av;
      av = 16'h1234 + 16'(k * 16'h1111);
      run_cycle(VECS[k], 16'hA000 + 16'(k), av,
                cs_cnt, first_cs, ale_cnt, rdy_i, oe_bad, addr_bad, after_rdy, data, err);
      // R2 cycle length and ready clock; R7 stretched chip-select window
      chk($sformatf("R2 R7 ready clock row %0d", k), rdy_i, int'(VECS[k].rdy));
      chk($sformatf("R7 cs low clocks row %0d", k), cs_cnt, int'(VECS[k].cs));
      chk($sformatf("R7 cs first clock row %0d", k), first_cs, int'(VECS[k].dly));
      chk($sformatf("R3 ale clocks row %0d", k), ale_cnt, 1);
      chk($sformatf("R3 addr hold row %0d", k), addr_bad, 0);
      chk($sformatf("R4 oe follows cs row %0d", k), oe_bad, 0);
      // R5 fixed capture, R6 acknowledge capture, R8 polarity in row 3
      chk($sformatf("R5 R6 R8 rdata row %0d", k), data, av);
      chk($sformatf("R10 err row %0d", k), err, 0);
      chk($sformatf("R10 single ready row %0d", k), after_rdy, 1);
      last_data = av;
    end

    // R9 timeout: no acknowledge at all
    run_cycle('{1'b1, 1'b0, 2'd0, 8'd28, 8'd0, 8'd3, -16'sd1, 16'd0, 16'd0, 16'd300},
              16'h5A5A, 16'hFFFF,
              cs_cnt, first_cs, ale_cnt, rdy_i, oe_bad, addr_bad, after_rdy, data, err);
    chk("R9 timeout ready clock", rdy_i, 258);
    chk("R9 timeout cs low clocks", cs_cnt, 258);
    chk("R9 err flag", err, 1);
    chk("R9 rdata kept", data, last_data);
    chk("R10 ready one clock after timeout", after_rdy, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule